// File: doc/BRIEF.md
# Multicycle Stored-Program Processor

This block is a small general-purpose processor. It holds a program memory and a data memory, each with 256 words of 16 bits, and a register file of sixteen 16-bit registers. A three-state controller works through each instruction. In FETCH it latches the word at the program counter into the instruction register. In DECODE it reads the operand registers. In EXECUTE it does the ALU work, the register or memory write and the program counter update. Every instruction therefore takes three clocks.

While `run` is low the controller waits in FETCH. In that time the surrounding logic can fill either memory through the load port and can inspect any register or data word through the peek ports. Raising `run` starts execution from the current program counter. `done` goes high for one cycle after each instruction finishes EXECUTE, and its results can be observed from that cycle on.

The states are FETCH, DECODE and EXECUTE. The transitions are FETCH→DECODE when `run` is high, FETCH→FETCH when `run` is low, DECODE→EXECUTE always, and EXECUTE→FETCH always. An instruction that has started always runs to completion.

Top module: `simple_cpu`

## Requirements
- R1: After reset the program counter is 0, `done` is low and the controller waits in FETCH.
- R2: With `run` high, each instruction takes exactly 3 clocks and `done` pulses once per instruction. The first pulse comes 3 clocks after `run` rises. With `run` low the program counter holds and `done` stays low.
- R3: Opcode 0011 (load-constant) writes bits 7..0, zero-extended to 16 bits, into the register named in bits 11..8.
- R4: Opcode 0010 (add) writes reg[bits 7..4] + reg[bits 3..0], modulo 2^16, into reg[bits 11..8].
- R5: Opcode 0100 (subtract) writes reg[bits 7..4] − reg[bits 3..0], modulo 2^16, into reg[bits 11..8].
- R6: Opcode 0000 (load) copies data word [bits 7..0] into reg[bits 11..8].
- R7: Opcode 0001 (store) writes reg[bits 11..8] into data word [bits 7..0] and leaves every other data word unchanged.
- R8: Opcode 0101 (jump-if-zero) loads bits 7..0 into the program counter when all 16 bits of reg[bits 11..8] are zero.
- R9: Jump-if-zero on a non-zero register, including one whose low byte is zero, advances the program counter by one.
- R10: Opcodes 0110 to 1111 change no register and no data word, and they advance the program counter by one.
- R11: The program counter is 8 bits wide, so advancing from 255 gives 0.
- R12: An instruction may name the same register as a source and as the destination. Sources are read before the result is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Execute instructions while high |
| load_imem_we | input | 1 | Write `load_data` into program memory (only used while `run` is low) |
| load_dmem_we | input | 1 | Write `load_data` into data memory (only used while `run` is low) |
| load_addr | input | 8 | Address for the load port |
| load_data | input | 16 | Data for the load port |
| peek_reg_addr | input | 4 | Register to observe |
| peek_reg_data | output | 16 | Contents of the observed register |
| peek_mem_addr | input | 8 | Data word to observe (valid outside EXECUTE) |
| peek_mem_data | output | 16 | Contents of the observed data word |
| pc | output | 8 | Program counter |
| done | output | 1 | One-cycle pulse after each completed instruction |

## Verification
The bench runs add and subtract over every pair drawn from a set of edge values (0, 1, 0x7FFF, 0x8000, 0xFFFF and others), so a carry or borrow that is dropped or kept at the wrong width shows up as a wrong sum. Operand order and shared source/destination registers are also covered, which catches subtraction that reverses its operands or reads a source after it has been overwritten. Jump-if-zero is tried on a zero register, a small non-zero value and a value whose only set bit lies in the high byte, which exposes a test that looks at only part of the word. A jump to address 255 followed by a step past it exposes a counter that does not wrap. Every undefined opcode is run against a live register and data word, and a decoder that writes anyway or skips the increment would corrupt them or the program counter.

// File: rtl/simple_cpu_pkg.sv
package simple_cpu_pkg;

    typedef enum logic [3:0] {
        OP_LOAD  = 4'h0,
        OP_STORE = 4'h1,
        OP_ADD   = 4'h2,
        OP_LDC   = 4'h3,
        OP_SUB   = 4'h4,
        OP_JZ    = 4'h5
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC
    } cpu_state_e;

    // Fixed 16-bit format: bits 7..0 double as immediate / data address
    typedef struct packed {
        logic [3:0] op;
        logic [3:0] dst;
        logic [3:0] src1;
        logic [3:0] src2;
    } instr_t;

endpackage

// File: rtl/cpu_ram.sv
module cpu_ram #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int RAW = 4,
    parameter int DW  = 16,
    parameter int NRD = 4
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [RAW-1:0]           waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [NRD-1:0][RAW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]   rdata
);
    localparam int NREG = 1 << RAW;

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we) regs[waddr] <= wdata;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = regs[raddr[g]];
    end

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] y
);
    always_comb begin
        if (sub) y = a - b;
        else     y = a + b;
    end

endmodule

// File: rtl/simple_cpu.sv
module simple_cpu
    import simple_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int MEM_AW = 8,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load_imem_we,
    input  logic              load_dmem_we,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic [REG_AW-1:0] peek_reg_addr,
    output logic [DATA_W-1:0] peek_reg_data,
    input  logic [MEM_AW-1:0] peek_mem_addr,
    output logic [DATA_W-1:0] peek_mem_data,
    output logic [MEM_AW-1:0] pc,
    output logic              done
);
    localparam int NRD = 4;

    cpu_state_e state, state_nx;
    instr_t            ir_q;
    logic [MEM_AW-1:0] pc_q, pc_nx;
    logic [DATA_W-1:0] opa_q, opb_q, opr_q;
    logic              done_q;

    logic [DATA_W-1:0] imem_rdata, dmem_rdata, alu_y, rf_wdata;
    logic [NRD-1:0][DATA_W-1:0] rf_rd;
    logic [MEM_AW-1:0] imm;
    logic              in_exec, rf_we, dmem_we;
    logic [MEM_AW-1:0] dmem_waddr, dmem_raddr;
    logic [DATA_W-1:0] dmem_wdata;

    assign imm     = MEM_AW'({ir_q.src1, ir_q.src2});
    assign in_exec = (state == ST_EXEC);

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_FETCH:  state_nx = run ? ST_DECODE : ST_FETCH;
            ST_DECODE: state_nx = ST_EXEC;
            ST_EXEC:   state_nx = ST_FETCH;
            default:   state_nx = ST_FETCH;
        endcase
    end

    // ---------------- per-state datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q   <= '0;
            pc_q   <= '0;
            opa_q  <= '0;
            opb_q  <= '0;
            opr_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= in_exec;
            unique case (state)
                ST_FETCH: if (run) ir_q <= instr_t'(imem_rdata);
                ST_DECODE: begin
                    opa_q <= rf_rd[0];
                    opb_q <= rf_rd[1];
                    opr_q <= rf_rd[2];
                end
                ST_EXEC: pc_q <= pc_nx;
                default: ;
            endcase
        end
    end

    // ---------------- execute decode ----------------
    always_comb begin
        pc_nx    = pc_q + MEM_AW'(1);
        rf_we    = 1'b0;
        rf_wdata = '0;
        unique case (ir_q.op)
            OP_LOAD: begin rf_we = in_exec; rf_wdata = dmem_rdata; end
            OP_ADD,
            OP_SUB:  begin rf_we = in_exec; rf_wdata = alu_y; end
            OP_LDC:  begin
                rf_we    = in_exec;
                rf_wdata = {{(DATA_W-MEM_AW){1'b0}}, imm};
            end
            OP_JZ:   if (opr_q == '0) pc_nx = imm;
            default: ;
        endcase
    end

    assign dmem_we    = in_exec ? (ir_q.op == OP_STORE) : (load_dmem_we && !run);
    assign dmem_waddr = in_exec ? imm : load_addr;
    assign dmem_wdata = in_exec ? opr_q : load_data;
    assign dmem_raddr = in_exec ? imm : peek_mem_addr;

    // ---------------- sub-blocks ----------------
    cpu_ram #(.AW(MEM_AW), .DW(DATA_W)) u_imem (
        .clk   (clk),
        .we    (load_imem_we && !run),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (pc_q),
        .rdata (imem_rdata)
    );

    cpu_ram #(.AW(MEM_AW), .DW(DATA_W)) u_dmem (
        .clk   (clk),
        .we    (dmem_we),
        .waddr (dmem_waddr),
        .wdata (dmem_wdata),
        .raddr (dmem_raddr),
        .rdata (dmem_rdata)
    );

    cpu_regfile #(.RAW(REG_AW), .DW(DATA_W), .NRD(NRD)) u_rf (
        .clk   (clk),
        .we    (rf_we),
        .waddr (ir_q.dst),
        .wdata (rf_wdata),
        .raddr ({peek_reg_addr, ir_q.dst, ir_q.src2, ir_q.src1}),
        .rdata (rf_rd)
    );

    cpu_alu #(.DW(DATA_W)) u_alu (
        .a   (opa_q),
        .b   (opb_q),
        .sub (ir_q.op == OP_SUB),
        .y   (alu_y)
    );

    assign peek_reg_data = rf_rd[3];
    assign peek_mem_data = dmem_rdata;
    assign pc            = pc_q;
    assign done          = done_q;

    // ---------------- assertions ----------------
    p_seq_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && run) |=> (state == ST_DECODE));

    p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_EXEC) |=> $stable(pc_q));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    p_jump_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && ir_q.op == OP_JZ && opr_q == '0) |=> (pc_q == $past(imm)));

    p_undef_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && ir_q.op > 4'h5) |=> (pc_q == $past(pc_q) + MEM_AW'(1)));

    p_undef_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && ir_q.op > 4'h5) |-> (!rf_we && !dmem_we));

endmodule

// File: tb/tb_simple_cpu.sv
module tb_simple_cpu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        load_imem_we = 1'b0;
    logic        load_dmem_we = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [15:0] load_data = '0;
    logic [3:0]  peek_reg_addr = '0;
    logic [15:0] peek_reg_data;
    logic [7:0]  peek_mem_addr = '0;
    logic [15:0] peek_mem_data;
    logic [7:0]  pc;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit timed_out = 1'b0;
    localparam int WATCHDOG = 150000;

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    simple_cpu dut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .load_imem_we(load_imem_we), .load_dmem_we(load_dmem_we),
        .load_addr(load_addr), .load_data(load_data),
        .peek_reg_addr(peek_reg_addr), .peek_reg_data(peek_reg_data),
        .peek_mem_addr(peek_mem_addr), .peek_mem_data(peek_mem_data),
        .pc(pc), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_imem(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        load_imem_we = 1'b1; load_addr = a; load_data = d;
        @(negedge clk);
        load_imem_we = 1'b0;
    endtask

    task automatic put_dmem(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        load_dmem_we = 1'b1; load_addr = a; load_data = d;
        @(negedge clk);
        load_dmem_we = 1'b0;
    endtask

    task automatic get_reg(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        peek_reg_addr = a;
        #1 d = peek_reg_data;
    endtask

    task automatic get_mem(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        peek_mem_addr = a;
        #1 d = peek_mem_data;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // run n instructions; check 3-clock spacing of done pulses (R2)
    task automatic run_n(input int n);
        int seen = 0;
        int gap = 0;
        @(negedge clk); run = 1'b1;
        while (seen < n) begin
            @(negedge clk);
            gap++;
            if (cyc > WATCHDOG) begin
                if (!timed_out) begin
                    timed_out = 1'b1;
                    checks++; errors++;
                    $display("FAIL watchdog: actual %0d expected below %0d", cyc, WATCHDOG);
                end
                break;
            end
            if (done) begin
                seen++;
                chk("R2 done spacing", gap, 3);
                gap = 0;
            end
        end
        run = 1'b0;
    endtask

    function automatic logic [15:0] edge_val(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h7FFF;
            3: return 16'h8000;
            4: return 16'hFFFF;
            5: return 16'h1234;
            6: return 16'hFFFE;
            default: return 16'h00FF;
        endcase
    endfunction

    initial begin
        logic [15:0] d;
        logic [7:0]  p0;
        logic [15:0] a, b;

        // R1: reset state
        do_reset();
        #1;
        chk("R1 pc after reset", pc, 8'h00);
        chk("R1 done after reset", done, 1'b0);

        // R6/R3: load then load-constant zero-extends over a full register
        put_dmem(8'h00, 16'hFFFF);
        put_imem(8'h00, 16'h0500);   // load r5 <- dmem[0]
        put_imem(8'h01, 16'h35C3);   // ldc r5, 0xC3
        do_reset();
        run_n(1);
        get_reg(4'h5, d); chk("R6 load", d, 16'hFFFF);
        // R2: held with run low
        p0 = pc;
        repeat (5) begin
            @(negedge clk);
            if (done) chk("R2 no done while idle", done, 1'b0);
        end
        chk("R2 pc holds while idle", pc, p0);
        run_n(1);
        get_reg(4'h5, d); chk("R3 load-constant zero-extend", d, 16'h00C3);

        // R4/R5/R6/R7/R12: arithmetic sweep over edge-value pairs
        put_imem(8'h00, 16'h0100);   // load r1 <- [0]
        put_imem(8'h01, 16'h0201);   // load r2 <- [1]
        put_imem(8'h02, 16'h2312);   // add r3 = r1 + r2
        put_imem(8'h03, 16'h4412);   // sub r4 = r1 - r2
        put_imem(8'h04, 16'h1302);   // store r3 -> [2]
        put_imem(8'h05, 16'h1403);   // store r4 -> [3]
        put_imem(8'h06, 16'h2111);   // add r1 = r1 + r1
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                a = edge_val(i);
                b = edge_val(j);
                put_dmem(8'h00, a);
                put_dmem(8'h01, b);
                do_reset();
                run_n(7);
                get_reg(4'h3, d); chk("R4 add wrap", d, 16'(a + b));
                get_reg(4'h4, d); chk("R5 sub wrap", d, 16'(a - b));
                get_reg(4'h1, d); chk("R12 same src and dst", d, 16'(a + a));
                get_mem(8'h02, d); chk("R7 store sum", d, 16'(a + b));
                get_mem(8'h03, d); chk("R7 store diff", d, 16'(a - b));
                get_mem(8'h01, d); chk("R7 other word kept", d, b);
                chk("R2 pc after seven", pc, 8'h07);
            end
        end

        // R8: jump taken
        put_imem(8'h00, 16'h3211);   // ldc r2,0x11
        put_imem(8'h01, 16'h3100);   // ldc r1,0
        put_imem(8'h02, 16'h510A);   // jz r1 -> 10
        put_imem(8'h03, 16'h3255);   // ldc r2,0x55 (skipped)
        put_imem(8'h0A, 16'h3307);   // ldc r3,7
        do_reset();
        run_n(3);
        chk("R8 jump target", pc, 8'h0A);
        run_n(1);
        get_reg(4'h2, d); chk("R8 skipped instruction", d, 16'h0011);
        get_reg(4'h3, d); chk("R8 target executed", d, 16'h0007);
        chk("R8 pc after target", pc, 8'h0B);

        // R9: jump not taken, including high-byte-only value
        put_dmem(8'h00, 16'h0100);
        put_imem(8'h00, 16'h3105);   // ldc r1,5
        put_imem(8'h01, 16'h5114);   // jz r1 -> 0x14
        put_imem(8'h02, 16'h3266);   // ldc r2,0x66
        put_imem(8'h03, 16'h0100);   // load r1 <- [0] = 0x0100
        put_imem(8'h04, 16'h5130);   // jz r1 -> 0x30
        do_reset();
        run_n(2);
        chk("R9 small nonzero not taken", pc, 8'h02);
        run_n(1);
        get_reg(4'h2, d); chk("R9 fallthrough executed", d, 16'h0066);
        run_n(2);
        chk("R9 high-byte nonzero not taken", pc, 8'h05);

        // R10: undefined opcodes
        put_dmem(8'h05, 16'hABCD);
        put_imem(8'h00, 16'h3633);   // ldc r6,0x33
        for (int k = 0; k < 10; k++)
            put_imem(8'(k + 1), {4'(k + 6), 4'h6, 8'h05});
        do_reset();
        run_n(1);
        for (int k = 0; k < 10; k++) begin
            run_n(1);
            chk("R10 undefined advances pc", pc, 8'(k + 2));
        end
        get_reg(4'h6, d); chk("R10 register untouched", d, 16'h0033);
        get_mem(8'h05, d); chk("R10 data word untouched", d, 16'hABCD);

        // R11: pc wrap from 255
        put_imem(8'h00, 16'h3000);   // ldc r0,0
        put_imem(8'h01, 16'h50FF);   // jz r0 -> 255
        put_imem(8'hFF, 16'h3709);   // ldc r7,9
        do_reset();
        run_n(2);
        chk("R8 jump to 255", pc, 8'hFF);
        run_n(1);
        chk("R11 pc wraps to 0", pc, 8'h00);
        get_reg(4'h7, d); chk("R11 last word executed", d, 16'h0009);
        run_n(1);
        chk("R11 continues from 0", pc, 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule